// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block watches 32 external interrupt pins, grouped into four banks of eight, and turns activity on them into interrupt requests. Each pin has its own trigger selection: a low or high level, a falling or rising edge, or either edge. A qualifying event sets a pending flag for that pin. A mask then decides whether the flag reaches an output.

The lower sixteen pins each drive their own request line. The upper sixteen pins are merged into a single shared request, which is the OR of every unmasked pending flag in banks 2 and 3.

Software reaches each bank through a small register window with three registers: trigger configuration, mask, and pending. A pending flag is cleared by writing 1 to it. The pin inputs are asynchronous, so they pass through a two-flop synchroniser before detection.

Top module: `eint_ctrl`

## Requirements
- R1: A pin change is synchronised first. A change driven between clock edges shows as a pending flag after the third rising edge that follows it, and not after the second.
- R2: The 3-bit trigger code selects the detection: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge, 4 = both edges. Codes 5, 6 and 7 never set a pending flag.
- R3: For the level codes, a clear has no lasting effect while the level condition still holds, because detection beats clear in the same cycle. Once the level is gone, a clear removes the flag.
- R4: In a configuration register, pin k of the bank uses bits [4k+2:4k]. Bit 4k+3 is not stored and reads as 0.
- R5: A mask bit of 1 blocks that pin's output. The pending flag still captures events while the pin is masked.
- R6: Writing 1 to a bit of a pending register clears that flag, and writing 0 leaves it unchanged. Without a clear, a pending flag never falls.
- R7: `irq_lines[k]` for k in 0..15 is high exactly when pin k is pending and unmasked.
- R8: `irq_shared` is high when any pin 16..31 is pending and unmasked, in either of the two upper banks.
- R9: After reset, every configuration register reads 0, every mask register reads 0xFF, and all outputs are low.
- R10: The register address is {bank[1:0], sel[1:0]}: sel 0 = configuration, 1 = mask (data bits [7:0]), 2 = pending (data bits [7:0]). Sel 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 32 | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {bank, sel} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq_lines | output | 16 | Per-pin requests for pins 0..15 |
| irq_shared | output | 1 | Merged request for pins 16..31 |

## Verification
A wrong trigger decode, or a lost or spurious pending flag, shows in the pending register and on the request outputs three edges after the pin changes. The bench samples at exactly that edge, so an extra or missing synchroniser stage is caught. A mask or clear fault shows on the outputs in the cycle after the register write. Level-trigger faults appear when a clear fails to stick or fails to release.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int TYPE_W  = 3;
    localparam int FIELD_W = 4;

    typedef enum logic [TYPE_W-1:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_t;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    // Trigger decision from the synchronised level and its previous sample.
    function automatic logic trig_hit(input logic [TYPE_W-1:0] kind,
                                      input logic cur, input logic prev);
        logic hit;
        case (kind)
            TRIG_LOW:  hit = !cur;
            TRIG_HIGH: hit = cur;
            TRIG_FALL: hit = prev && !cur;
            TRIG_RISE: hit = !prev && cur;
            TRIG_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/eint_bank.sv
module eint_bank
    import eint_pkg::*;
#(
    parameter  int PINS   = 8,
    localparam int DATA_W = PINS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_s,
    input  logic              we_cfg,
    input  logic              we_mask,
    input  logic              we_pend,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q,
    output logic [PINS-1:0]   mask_q,
    output logic [PINS-1:0]   pend_q
);
    localparam int PAD_W = FIELD_W - TYPE_W;

    logic [PINS-1:0][TYPE_W-1:0] kind_q;
    logic [PINS-1:0]             prev_q;
    logic [PINS-1:0]             hit;
    logic [PINS-1:0]             clr;
    logic [PINS-1:0]             unused_pad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= '0;
        end else if (we_cfg) begin
            for (int k = 0; k < PINS; k++) begin
                kind_q[k] <= wdata[k*FIELD_W +: TYPE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (we_mask) begin
            mask_q <= wdata[PINS-1:0];
        end
    end

    assign clr = we_pend ? wdata[PINS-1:0] : '0;

    // A detection in the same cycle wins over a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | hit;
        end
    end

    for (genvar k = 0; k < PINS; k++) begin : g_pin
        assign hit[k] = trig_hit(kind_q[k], pin_s[k], prev_q[k]);
        assign cfg_q[k*FIELD_W +: FIELD_W] = {{PAD_W{1'b0}}, kind_q[k]};
        assign unused_pad[k] = ^wdata[k*FIELD_W+TYPE_W +: PAD_W];
    end
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter  int NUM_BANKS     = 4,
    parameter  int PINS_PER_BANK = 8,
    parameter  int DIRECT_PINS   = 16,
    localparam int NUM_PINS      = NUM_BANKS * PINS_PER_BANK,
    localparam int DATA_W        = PINS_PER_BANK * FIELD_W,
    localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W        = BANK_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    pins_in,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic [DIRECT_PINS-1:0] irq_lines,
    output logic                   irq_shared
);
    logic [NUM_PINS-1:0]         pin_s;
    logic [NUM_PINS-1:0]         pend_all;
    logic [NUM_PINS-1:0]         mask_all;
    logic [NUM_PINS*FIELD_W-1:0] cfg_all;
    logic [BANK_W-1:0]           acc_bank;
    reg_sel_t                    acc_sel;

    assign acc_bank = reg_addr[ADDR_W-1:2];
    assign acc_sel  = reg_sel_t'(reg_addr[1:0]);

    eint_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (pin_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_bank;
        assign hit_bank = reg_we && (acc_bank == BANK_W'(b));

        eint_bank #(.PINS(PINS_PER_BANK)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_s[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .we_cfg  (hit_bank && (acc_sel == SEL_CFG)),
            .we_mask (hit_bank && (acc_sel == SEL_MASK)),
            .we_pend (hit_bank && (acc_sel == SEL_PEND)),
            .wdata   (reg_wdata),
            .cfg_q   (cfg_all[b*DATA_W +: DATA_W]),
            .mask_q  (mask_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pend_q  (pend_all[b*PINS_PER_BANK +: PINS_PER_BANK])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(acc_bank) < NUM_BANKS) begin
            unique case (acc_sel)
                SEL_CFG:  reg_rdata = cfg_all[acc_bank*DATA_W +: DATA_W];
                SEL_MASK: reg_rdata = {{(DATA_W-PINS_PER_BANK){1'b0}},
                                       mask_all[acc_bank*PINS_PER_BANK +: PINS_PER_BANK]};
                SEL_PEND: reg_rdata = {{(DATA_W-PINS_PER_BANK){1'b0}},
                                       pend_all[acc_bank*PINS_PER_BANK +: PINS_PER_BANK]};
                SEL_NONE: reg_rdata = '0;
            endcase
        end
    end

    assign irq_lines  = pend_all[DIRECT_PINS-1:0] & ~mask_all[DIRECT_PINS-1:0];
    assign irq_shared = |(pend_all[NUM_PINS-1:DIRECT_PINS] & ~mask_all[NUM_PINS-1:DIRECT_PINS]);
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk
    import eint_pkg::*;
#(
    parameter  int NUM_BANKS     = 4,
    parameter  int PINS_PER_BANK = 8,
    parameter  int DIRECT_PINS   = 16,
    localparam int NUM_PINS      = NUM_BANKS * PINS_PER_BANK,
    localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W        = BANK_W + 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_we,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [PINS_PER_BANK-1:0]     wlow,
    input logic [DIRECT_PINS-1:0]       irq_lines,
    input logic                         irq_shared,
    input logic [NUM_PINS-1:0]          pend_all,
    input logic [NUM_PINS-1:0]          mask_all,
    input logic [NUM_PINS*FIELD_W-1:0]  cfg_all
);
    function automatic logic [NUM_PINS*FIELD_W-1:0] pad_bits();
        logic [NUM_PINS*FIELD_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_PINS; k++) m[k*FIELD_W + TYPE_W] = 1'b1;
        return m;
    endfunction

    localparam logic [NUM_PINS*FIELD_W-1:0] PAD_MASK = pad_bits();

    logic [NUM_PINS-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (reg_we && reg_addr[1:0] == SEL_PEND) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (reg_addr[ADDR_W-1:2] == BANK_W'(b))
                    clr_vec[b*PINS_PER_BANK +: PINS_PER_BANK] = wlow;
            end
        end
    end

    // R6: a flag falls only where a 1 was written to it
    assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_all) & ~pend_all & ~$past(clr_vec)) == '0))
        else $error("pending flag fell without a clear");

    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_lines & mask_all[DIRECT_PINS-1:0]) == '0))
        else $error("masked pin drives its line");

    assert_shared_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_all[NUM_PINS-1:DIRECT_PINS]) |-> !irq_shared)
        else $error("shared line high with upper pins all masked");

    assert_reset_vals_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&mask_all) && (cfg_all == '0)))
        else $error("register reset values wrong");

    assert_cfg_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_all & PAD_MASK) == '0))
        else $error("unused configuration bit set");

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_quiet
        assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cfg_all[k*FIELD_W +: TYPE_W]) >= 3'd5) |-> !$rose(pend_all[k]))
            else $error("disabled trigger code set a flag");
    end
endmodule

bind eint_ctrl eint_ctrl_chk #(
    .NUM_BANKS     (NUM_BANKS),
    .PINS_PER_BANK (PINS_PER_BANK),
    .DIRECT_PINS   (DIRECT_PINS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .wlow       (reg_wdata[PINS_PER_BANK-1:0]),
    .irq_lines  (irq_lines),
    .irq_shared (irq_shared),
    .pend_all   (pend_all),
    .mask_all   (mask_all),
    .cfg_all    (cfg_all)
);

// File: tb/tb_eint_ctrl.sv
module tb_eint_ctrl;
    localparam int NP = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins;
    logic          reg_we;
    logic [3:0]    reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic [15:0]   irq_lines;
    logic          irq_shared;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    eint_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_in    (pins),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_lines  (irq_lines),
        .irq_shared (irq_shared)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ra(input int bank, input int sel);
        return 4'(bank * 4 + sel);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_type(input int p, input int t);
        logic [31:0] v;
        rd(ra(p / 8, 0), v);
        v[(p % 8) * 4 +: 4] = 4'(t);
        wr(ra(p / 8, 0), v);
    endtask

    function automatic logic exp_pend(input int t, input logic o, input logic n);
        case (t)
            0:       return !o || !n;
            1:       return o || n;
            2:       return o && !n;
            3:       return !o && n;
            4:       return o != n;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          seed;
        rst_n = 1'b0; pins = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        seed = $urandom(32'h0000_5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        check("R9 irq_lines", 32'(irq_lines), 32'h0);
        check("R9 irq_shared", 32'(irq_shared), 32'h0);
        for (int b = 0; b < 4; b++) begin
            rd(ra(b, 0), v); check("R9 cfg", v, 32'h0);
            rd(ra(b, 1), v); check("R9 mask", v, 32'hFF);
        end

        // R1 latency on a rising edge of pin 3
        set_type(3, 3);
        wr(ra(0, 2), 32'hFF);
        pins[3] = 1'b1;
        tick(2);
        rd(ra(0, 2), v); check("R1 not yet pending", 32'(v[3]), 32'h0);
        tick(1);
        rd(ra(0, 2), v); check("R1 pending after sync", 32'(v[3]), 32'h1);

        // R5 masked pin still pending, output held low
        check("R5 masked output", 32'(irq_lines), 32'h0);
        wr(ra(0, 1), 32'hF7);
        check("R7 direct line", 32'(irq_lines), 32'h0008);
        wr(ra(0, 2), 32'h00);
        check("R6 write zero keeps", 32'(irq_lines), 32'h0008);
        wr(ra(0, 2), 32'h08);
        check("R6 write one clears", 32'(irq_lines), 32'h0000);
        rd(ra(0, 2), v); check("R6 flag cleared", 32'(v[3]), 32'h0);
        wr(ra(0, 1), 32'hFF);

        // R3 low-level pin 10 survives a clear, then releases
        wr(ra(1, 2), 32'h04);
        rd(ra(1, 2), v); check("R3 level holds through clear", 32'(v[2]), 32'h1);
        pins[10] = 1'b1;
        tick(3);
        wr(ra(1, 2), 32'h04);
        rd(ra(1, 2), v); check("R3 clear after level gone", 32'(v[2]), 32'h0);

        // R8 shared output from both upper banks
        set_type(20, 1);
        wr(ra(2, 2), 32'hFF);
        wr(ra(2, 1), 32'hEF);
        check("R8 shared idle", 32'(irq_shared), 32'h0);
        pins[20] = 1'b1;
        tick(3);
        check("R8 shared from bank 2", 32'(irq_shared), 32'h1);
        pins[20] = 1'b0;
        tick(3);
        wr(ra(2, 2), 32'h10);
        check("R8 shared after clear", 32'(irq_shared), 32'h0);
        wr(ra(3, 1), 32'hDF);
        check("R8 shared from bank 3", 32'(irq_shared), 32'h1);
        wr(ra(2, 1), 32'hFF);
        wr(ra(3, 1), 32'hFF);
        check("R8 shared remasked", 32'(irq_shared), 32'h0);

        // R4 field layout, R10 unused address
        wr(ra(1, 0), 32'hFFFF_FFFF);
        rd(ra(1, 0), v); check("R4 pad bits read zero", v, 32'h7777_7777);
        wr(ra(1, 0), 32'h0);
        wr(ra(0, 3), 32'hFFFF_FFFF);
        rd(ra(0, 3), v); check("R10 sel 3 reads zero", v, 32'h0);
        rd(ra(0, 0), v); check("R10 cfg untouched", v, 32'h0000_3000);
        rd(ra(0, 1), v); check("R10 mask untouched", v, 32'hFF);

        // R2 random trigger codes and transitions
        for (int i = 0; i < 48; i++) begin
            int   p, t;
            logic o, n, e;
            p = int'($urandom % 32);
            t = int'($urandom % 8);
            o = 1'($urandom % 2);
            n = 1'($urandom % 2);
            e = exp_pend(t, o, n);
            set_type(p, t);
            pins[p] = o;
            tick(4);
            wr(ra(p / 8, 2), 32'(1) << (p % 8));
            pins[p] = n;
            tick(3);
            rd(ra(p / 8, 2), v);
            check($sformatf("R2 pin %0d code %0d %0b->%0b", p, t, o, n), 32'(v[p % 8]), 32'(e));
            wr(ra(p / 8, 1), 32'hFF & ~(32'(1) << (p % 8)));
            if (p < 16) check("R7 random line", 32'(irq_lines[p]), 32'(e));
            else        check("R8 random shared", 32'(irq_shared), 32'(e));
            wr(ra(p / 8, 1), 32'hFF);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule